// File: doc/BRIEF.md
# Write-Masked PHY Configuration Register Port

This block is a small 32-bit register bank that sits between a simple bus port and a PHY. It differs from an ordinary register bank in how writes work. Each write carries its own per-bit enable mask in the upper 16 bits of the word. Only the lower-half bits whose mask bit is set take the new value, so software can change single fields without reading the register first.

The bank has three registers:
- **Configuration register.** It packs an indirect address, a 4-bit data value and a strobe bit. When the strobe bit goes from 0 to 1, the data value is committed into a small internal store of 4-bit PHY settings, at the given address. A second port lets the PHY side read any entry of that store.
- **Lane-idle register.** It holds one idle control per lane.
- **Status register.** It is read-only and reports two PLL conditions taken from input pins.

Reads are combinational. A read returns the addressed register with all unimplemented bits at zero.

Top module: `phy_cfg_regport`

## Requirements
- R1: For every write, bit n (n = 0..15) of the addressed register takes bit n of the written word only when bit n+16 of the same word is 1. Otherwise bit n keeps its old value.
- R2: Register word addresses are fixed: the configuration register is at 0, the lane-idle register is at 1 and the status register is at 2. In the configuration register, bit 0 is the strobe, bits 6:1 are the settings address and bits 10:7 are the settings data. Bits 15:11 of the configuration register read as zero.
- R3: If a write changes the stored strobe from 0 to 1, then on the following clock edge the settings entry at the stored address takes the stored data. At the same time, cfg_wr_o is high for exactly that one cycle.
- R4: No commit happens while the strobe stays 1, even if the address or data fields are rewritten. No commit happens when the strobe falls. A commit happens only once per 0-to-1 transition.
- R5: Lane-idle bits sit at positions 3, 4, 5 and 6, for lanes 0, 1, 2 and 3. A value of 1 idles the lane and 0 makes it active. lane_idle_o[k] follows bit 3+k. All other bits of this register read as zero.
- R6: The status register reads pll_locked_i at bit 9 and pll_out_pending_i at bit 10, with every other bit zero. Writes to the status register are ignored.
- R7: Read data bits 31:16 are always zero. Word address 3 reads as zero, and writes to it change nothing.
- R8: Reset clears both stored registers and every settings entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write request this cycle |
| wr_addr_i | input | 2 | Word address of the write |
| wr_data_i | input | 32 | Upper half is the per-bit mask, lower half is the value |
| rd_addr_i | input | 2 | Word address of the read |
| rd_data_o | output | 32 | Read data (combinational) |
| pll_locked_i | input | 1 | PLL locked indication |
| pll_out_pending_i | input | 1 | PLL output-enable pending indication |
| lane_idle_o | output | 4 | Per-lane idle controls |
| cfg_wr_o | output | 1 | One-cycle pulse when a settings entry is committed |
| cfg_rd_addr_i | input | 6 | PHY-side settings read address |
| cfg_rd_data_o | output | 4 | PHY-side settings read data |

## Verification
The bench goes after three kinds of errors:
- **Ignoring the mask or applying it to the wrong half.** Writes whose masks are random and sparse expose this, because wrong bits change or stay put.
- **Committing on level instead of on edge.** The bench holds the strobe at 1 while it rewrites the address and data. A level-triggered design would overwrite the entry and emit extra cfg_wr_o pulses, which the bench counts.
- **Leaking bits that should read as zero.** The bench writes all-ones to the status register and to the unmapped address. A design that stored those writes, or that returned mask bits on reads, would show nonzero bits where only zero or live PLL inputs belong.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  // word offsets
  localparam int unsigned OFF_CFG  = 0;
  localparam int unsigned OFF_LANE = 1;
  localparam int unsigned OFF_STAT = 2;

  // configuration register layout (data LSB derived from address width)
  localparam int unsigned CFG_STRB_BIT = 0;
  localparam int unsigned CFG_ADDR_LSB = 1;

  // lane-idle register
  localparam int unsigned LANE_LSB = 3;

  // status register
  localparam int unsigned STAT_LOCK_BIT = 9;
  localparam int unsigned STAT_PEND_BIT = 10;

  function automatic logic [HALF_W-1:0] masked_next(
    input logic [HALF_W-1:0] cur,
    input logic [WORD_W-1:0] wd,
    input logic [HALF_W-1:0] impl
  );
    logic [HALF_W-1:0] en;
    en = wd[WORD_W-1:HALF_W] & impl;
    return (cur & ~en) | (wd[HALF_W-1:0] & en);
  endfunction
endpackage

// File: rtl/hiword_reg.sv
module hiword_reg
  import phy_cfg_pkg::*;
#(
  parameter logic [HALF_W-1:0] IMPL_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [HALF_W-1:0] q_o
);
  logic [HALF_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (we_i) q <= masked_next(q, wdata_i, IMPL_MASK);
  end

  assign q_o = q;
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          commit_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic          strobe_q;
  logic          commit;
  logic [DW-1:0] mem [DEPTH];

  // edge, not level: one commit per rising strobe
  assign commit = strobe_i & ~strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[e] <= '0;
      else if (commit && addr_i == AW'(e)) mem[e] <= data_i;
    end
  end

  assign commit_o  = commit;
  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/reg_rd_mux.sv
module reg_rd_mux
  import phy_cfg_pkg::*;
#(
  parameter int unsigned BUS_AW = 2
) (
  input  logic [BUS_AW-1:0] rd_addr_i,
  input  logic [HALF_W-1:0] cfg_q_i,
  input  logic [HALF_W-1:0] lane_q_i,
  input  logic              pll_locked_i,
  input  logic              pll_out_pending_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [HALF_W-1:0] stat;

  always_comb begin
    stat = '0;
    stat[STAT_LOCK_BIT] = pll_locked_i;
    stat[STAT_PEND_BIT] = pll_out_pending_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == BUS_AW'(OFF_CFG))       rd_data_o[HALF_W-1:0] = cfg_q_i;
    else if (rd_addr_i == BUS_AW'(OFF_LANE)) rd_data_o[HALF_W-1:0] = lane_q_i;
    else if (rd_addr_i == BUS_AW'(OFF_STAT)) rd_data_o[HALF_W-1:0] = stat;
  end
endmodule

// File: rtl/phy_cfg_regport.sv
module phy_cfg_regport
  import phy_cfg_pkg::*;
#(
  parameter int unsigned BUS_AW = 2,
  parameter int unsigned LANES  = 4,
  parameter int unsigned CFG_AW = 6,
  parameter int unsigned CFG_DW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [BUS_AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  logic [BUS_AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0]     rd_data_o,
  input  logic                  pll_locked_i,
  input  logic                  pll_out_pending_i,
  output logic [LANES-1:0]      lane_idle_o,
  output logic                  cfg_wr_o,
  input  logic [CFG_AW-1:0]     cfg_rd_addr_i,
  output logic [CFG_DW-1:0]     cfg_rd_data_o
);
  localparam int unsigned CFG_DATA_LSB = CFG_ADDR_LSB + CFG_AW;
  localparam int unsigned CFG_USED     = CFG_DATA_LSB + CFG_DW;
  localparam logic [HALF_W-1:0] CFG_IMPL  = HALF_W'((32'd1 << CFG_USED) - 1);
  localparam logic [HALF_W-1:0] LANE_IMPL = HALF_W'(((32'd1 << LANES) - 1) << LANE_LSB);

  logic              we_cfg, we_lane;
  logic [HALF_W-1:0] cfg_q, lane_q;

  assign we_cfg  = wr_valid_i && (wr_addr_i == BUS_AW'(OFF_CFG));
  assign we_lane = wr_valid_i && (wr_addr_i == BUS_AW'(OFF_LANE));

  hiword_reg #(.IMPL_MASK(CFG_IMPL)) u_cfg_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_cfg),
    .wdata_i (wr_data_i),
    .q_o     (cfg_q)
  );

  hiword_reg #(.IMPL_MASK(LANE_IMPL)) u_lane_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_lane),
    .wdata_i (wr_data_i),
    .q_o     (lane_q)
  );

  cfg_store #(.AW(CFG_AW), .DW(CFG_DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (cfg_q[CFG_STRB_BIT]),
    .addr_i    (cfg_q[CFG_ADDR_LSB +: CFG_AW]),
    .data_i    (cfg_q[CFG_DATA_LSB +: CFG_DW]),
    .commit_o  (cfg_wr_o),
    .rd_addr_i (cfg_rd_addr_i),
    .rd_data_o (cfg_rd_data_o)
  );

  reg_rd_mux #(.BUS_AW(BUS_AW)) u_rd_mux (
    .rd_addr_i         (rd_addr_i),
    .cfg_q_i           (cfg_q),
    .lane_q_i          (lane_q),
    .pll_locked_i      (pll_locked_i),
    .pll_out_pending_i (pll_out_pending_i),
    .rd_data_o         (rd_data_o)
  );

  assign lane_idle_o = lane_q[LANE_LSB +: LANES];
endmodule

// File: rtl/phy_cfg_regport_chk.sv
module phy_cfg_regport_chk
  import phy_cfg_pkg::*;
#(
  parameter int unsigned BUS_AW = 2,
  parameter int unsigned LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [BUS_AW-1:0] wr_addr_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [BUS_AW-1:0] rd_addr_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              pll_locked_i,
  input logic [LANES-1:0]  lane_idle_o,
  input logic              cfg_wr_o
);
  // R3: a commit follows a configuration write in the previous cycle
  assert_commit_after_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> $past(wr_valid_i && wr_addr_i == BUS_AW'(OFF_CFG)));

  // R4: never two commits back to back
  assert_single_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o);

  // R1: lane 0 idle bit unchanged when its mask bit is clear
  assert_mask_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_addr_i == BUS_AW'(OFF_LANE) && !wr_data_i[HALF_W + LANE_LSB])
    |=> $stable(lane_idle_o[0]));

  // R5: lane 0 idle takes the written value when masked in
  assert_lane_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_addr_i == BUS_AW'(OFF_LANE) && wr_data_i[HALF_W + LANE_LSB])
    |=> lane_idle_o[0] == $past(wr_data_i[LANE_LSB]));

  // R6: status lock bit follows the pin
  assert_status_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == BUS_AW'(OFF_STAT)) |-> rd_data_o[STAT_LOCK_BIT] == pll_locked_i);

  // R8: lanes held active during reset
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_lanes_R8: assert (lane_idle_o == '0);
  end
endmodule

bind phy_cfg_regport phy_cfg_regport_chk #(.BUS_AW(BUS_AW), .LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .pll_locked_i (pll_locked_i),
  .lane_idle_o  (lane_idle_o),
  .cfg_wr_o     (cfg_wr_o)
);

// File: tb/phy_cfg_regport_tb.sv
module phy_cfg_regport_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        pll_locked_i = 1'b0;
  logic        pll_out_pending_i = 1'b0;
  logic [3:0]  lane_idle_o;
  logic        cfg_wr_o;
  logic [5:0]  cfg_rd_addr_i = '0;
  logic [3:0]  cfg_rd_data_o;

  phy_cfg_regport u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pll_locked_i(pll_locked_i), .pll_out_pending_i(pll_out_pending_i),
    .lane_idle_o(lane_idle_o), .cfg_wr_o(cfg_wr_o),
    .cfg_rd_addr_i(cfg_rd_addr_i), .cfg_rd_data_o(cfg_rd_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0, pulses = 0, exp_pulses = 0;
  logic [15:0] cfg_m = '0, lane_m = '0;
  logic [3:0]  store_m [64];

  always @(negedge clk_i) if (rst_ni && cfg_wr_o) pulses++;

  function automatic logic [15:0] upd(input logic [15:0] cur, input logic [31:0] wd,
                                      input logic [15:0] impl);
    logic [15:0] r = cur;
    for (int n = 0; n < 16; n++) if (wd[n+16] && impl[n]) r[n] = wd[n];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {16'h0, cfg_m};
      2'd1: return {16'h0, lane_m};
      2'd2: return {21'h0, pll_out_pending_i, pll_locked_i, 9'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic old_s;
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    @(negedge clk_i);
    old_s = cfg_m[0];
    if (a == 2'd0) cfg_m = upd(cfg_m, d, 16'h07FF);
    if (a == 2'd1) lane_m = upd(lane_m, d, 16'h0078);
    if (a == 2'd0 && !old_s && cfg_m[0]) begin
      store_m[cfg_m[6:1]] = cfg_m[10:7];
      exp_pulses++;
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int a = 0; a < 4; a++) begin
      rd_addr_i = 2'(a);
      #1;
      chk(tag, rd_data_o, exp_rd(2'(a)));
    end
    chk({tag, " lanes R5"}, {28'h0, lane_idle_o}, {28'h0, lane_m[6:3]});
  endtask

  task automatic chk_store(input string tag);
    for (int e = 0; e < 64; e++) begin
      cfg_rd_addr_i = 6'(e);
      #1;
      chk(tag, {28'h0, cfg_rd_data_o}, {28'h0, store_m[e]});
    end
  endtask

  function automatic logic [31:0] cfg_word(input logic [15:0] mask, input logic [3:0] d,
                                           input logic [5:0] a, input logic s);
    return {mask, 5'h0, d, a, s};
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    for (int e = 0; e < 64; e++) store_m[e] = '0;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    chk_regs("R8 reset");
    chk_store("R8 store reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3: commit 0xA to entry 5
    wr(2'd0, cfg_word(16'hFFFF, 4'hA, 6'd5, 1'b1));
    chk_regs("R2 cfg layout");
    cfg_rd_addr_i = 6'd5; #1;
    chk("R3 commit data", {28'h0, cfg_rd_data_o}, 32'hA);
    chk("R3 pulse count", pulses, exp_pulses);

    // R4: strobe held, fields rewritten -> no commit
    wr(2'd0, cfg_word(16'h07FF, 4'h3, 6'd5, 1'b1));
    cfg_rd_addr_i = 6'd5; #1;
    chk("R4 held strobe no commit", {28'h0, cfg_rd_data_o}, 32'hA);
    chk("R4 pulse count", pulses, exp_pulses);
    // R4: strobe falls -> no commit; then rises -> commit 0x3
    wr(2'd0, cfg_word(16'h0001, 4'h0, 6'd0, 1'b0));
    chk("R4 falling no pulse", pulses, exp_pulses);
    wr(2'd0, cfg_word(16'h0001, 4'h0, 6'd0, 1'b1));
    cfg_rd_addr_i = 6'd5; #1;
    chk("R3 recommit", {28'h0, cfg_rd_data_o}, 32'h3);

    // R1: mask-clear write changes nothing
    wr(2'd0, cfg_word(16'h0000, 4'hF, 6'h3F, 1'b0));
    chk_regs("R1 zero mask");

    // R5: lanes
    wr(2'd1, 32'h0078_0028);
    chk_regs("R5 lanes 0,2 idle");
    wr(2'd1, 32'h0010_0000);
    chk_regs("R5 lane 1 active");

    // R6 R7: writes to status and unmapped ignored
    pll_locked_i = 1'b1; pll_out_pending_i = 1'b0;
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    chk_regs("R6 R7 ignored writes");
    chk("R4 pulse count after ignored", pulses, exp_pulses);
    pll_locked_i = 1'b0; pll_out_pending_i = 1'b1;
    chk_regs("R6 status pins");

    // R1 R3 random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d = $urandom;
      logic [1:0]  a = 2'($urandom_range(0, 3));
      if (($urandom & 1) == 0) d[31:16] = d[31:16] & 16'($urandom);
      pll_locked_i = 1'($urandom); pll_out_pending_i = 1'($urandom);
      wr(a, d);
      if (i % 25 == 0) chk_regs("R1 random");
    end
    chk_regs("R1 random final");
    chk_store("R3 random store");
    chk("R3 R4 random pulses", pulses, exp_pulses);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule